// File: doc/BRIEF.md
# Sixteen-Bit Multimode Waveform Timer

This block is a 16-bit counter that produces one pulse-width-modulated output and two event flags. A 4-bit waveform mode is built from two 2-bit control fields. The mode picks the counting style, which is one of: free running, clear on compare, single-slope PWM, or dual-slope PWM. The mode also picks where the counting limit (TOP) comes from. TOP can be a fixed power-of-two-minus-one value, the active compare value, or a capture register that software writes.

Compare writes go into a buffer. That buffer is copied to the active compare value at a point that depends on the mode. The overflow flag is also raised at a point that depends on the mode. A single decode table in the package holds all of this per-mode behaviour.

The counter only moves in cycles where `cnt_en` is high. A prescaler or an event source outside the block drives that input. Each flag is cleared by a one-cycle clear pulse.

Top module: `wavegen_timer16`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, `count` is 0, both flags are 0 and `wave_out` is 0. The compare buffer, the active compare value and the capture register also reset to 0.
- R2: The mode is the 4-bit value {`mode_hi`,`mode_lo`}. In a cycle with `cnt_en` low, none of `count`, the flags or `wave_out` change because of counting.
- R3: In modes 0, 4, 5, 6, 7, 12, 13, 14 and 15 the counter counts up by one on each enabled cycle. It goes to 0 on the enabled cycle after it equals TOP. The fixed TOP is 0xFFFF in modes 0 and 13, 0x00FF in modes 1 and 5, 0x01FF in modes 2 and 6, and 0x03FF in modes 3 and 7.
- R4: TOP is the active compare value in modes 4, 9, 11 and 15. TOP is the capture register in modes 8, 10, 12 and 14.
- R5: Modes 1, 2, 3, 8, 9, 10 and 11 are dual-slope. The counter turns down on the enabled cycle where it is at or above TOP, and turns up on the enabled cycle where it is at 0. Each of TOP and 0 lasts one count. Every enabled step changes the count by exactly one.
- R6: A compare write always lands in the buffer on that edge. The active compare value is loaded from the buffer at one of three points, depending on the mode:
  - Modes 0, 4, 12 and 13: on every edge, taking the written value directly in a write cycle.
  - Modes 1, 2, 3, 10 and 11: on an enabled cycle with count equal to TOP.
  - Modes 5 to 9, 14 and 15: on an enabled cycle with count equal to 0.
- R7: `ovf_flag` is set on an enabled cycle where the count is at a mode-dependent point:
  - 0xFFFF in modes 0, 4, 12 and 13.
  - TOP in modes 5, 6, 7, 14 and 15.
  - 0 in the dual-slope modes.
- R8: `cmf_flag` is set on an enabled cycle whose count equals the active compare value.
- R9: A high `ovf_clr` or `cmf_clr` clears its flag on the next edge. A set in the same cycle takes priority over the clear.
- R10: In modes 5, 6, 7, 14 and 15, an enabled cycle at TOP drives `wave_out` to 1. Otherwise, an enabled cycle at the compare value drives it to 0.
- R11: In dual-slope modes, an enabled cycle at the compare value drives `wave_out` to 0 while counting up and to 1 while counting down.
- R12: In modes 0, 4, 12 and 13 `wave_out` holds its value. Mode 13 behaves as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable, one step per high cycle |
| mode_hi | input | 2 | Upper two mode bits |
| mode_lo | input | 2 | Lower two mode bits |
| cmpa_wr | input | 1 | Compare write strobe |
| cmpa_wdata | input | 16 | Compare write value |
| capt_wr | input | 1 | Capture register write strobe |
| capt_wdata | input | 16 | Capture register write value |
| ovf_clr | input | 1 | Overflow flag clear pulse |
| cmf_clr | input | 1 | Compare flag clear pulse |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Overflow flag |
| cmf_flag | output | 1 | Compare-match flag |
| wave_out | output | 1 | Waveform output |

## Verification
Every result of this block is registered. The count, both flags, the pin and the active compare value all change on the first rising edge after the enabled cycle or write that caused them. A write that is buffered takes effect only on a later enabled cycle at TOP or at 0.

The bench drives inputs just after a falling edge. It advances its reference model right after the rising edge, from the inputs that were stable at that edge. It then compares all four outputs at the following falling edge, so every check samples exactly one edge after its cause.

// File: rtl/wgt_pkg.sv
package wgt_pkg;

  typedef enum logic [1:0] {TS_FIXED, TS_CMPA, TS_CAPT} top_src_e;
  typedef enum logic [1:0] {LD_NOW, LD_TOP, LD_BOT} load_pt_e;
  typedef enum logic [1:0] {OV_MAX, OV_TOP, OV_BOT} ovf_pt_e;
  typedef enum logic [1:0] {WK_PLAIN, WK_FAST, WK_DUAL} wave_kind_e;

  // res_sel: 0 full width, 1 8-bit, 2 9-bit, 3 10-bit fixed limit
  typedef struct packed {
    top_src_e   top_src;
    logic [1:0] res_sel;
    load_pt_e   load_pt;
    ovf_pt_e    ovf_pt;
    wave_kind_e kind;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [3:0] m);
    mode_cfg_t c;
    c = '{top_src: TS_FIXED, res_sel: 2'd0, load_pt: LD_NOW, ovf_pt: OV_MAX, kind: WK_PLAIN};
    case (m)
      4'd1, 4'd2, 4'd3: begin
        c.res_sel = m[1:0];
        c.load_pt = LD_TOP;
        c.ovf_pt  = OV_BOT;
        c.kind    = WK_DUAL;
      end
      4'd4: c.top_src = TS_CMPA;
      4'd5, 4'd6, 4'd7: begin
        c.res_sel = m[1:0] - 2'd0;
        c.res_sel = (m == 4'd5) ? 2'd1 : (m == 4'd6) ? 2'd2 : 2'd3;
        c.load_pt = LD_BOT;
        c.ovf_pt  = OV_TOP;
        c.kind    = WK_FAST;
      end
      4'd8, 4'd9: begin
        c.top_src = (m == 4'd8) ? TS_CAPT : TS_CMPA;
        c.load_pt = LD_BOT;
        c.ovf_pt  = OV_BOT;
        c.kind    = WK_DUAL;
      end
      4'd10, 4'd11: begin
        c.top_src = (m == 4'd10) ? TS_CAPT : TS_CMPA;
        c.load_pt = LD_TOP;
        c.ovf_pt  = OV_BOT;
        c.kind    = WK_DUAL;
      end
      4'd12: c.top_src = TS_CAPT;
      4'd14, 4'd15: begin
        c.top_src = (m == 4'd14) ? TS_CAPT : TS_CMPA;
        c.load_pt = LD_BOT;
        c.ovf_pt  = OV_TOP;
        c.kind    = WK_FAST;
      end
      default: ; // 0 and the reserved code 13 count freely
    endcase
    return c;
  endfunction

endpackage

// File: rtl/wgt_mode_decode.sv
module wgt_mode_decode
  import wgt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [3:0]       mode,
  output mode_cfg_t        cfg,
  output logic [CNT_W-1:0] fixed_top
);
  localparam logic [CNT_W-1:0] TOP_FULL = '1;
  localparam logic [CNT_W-1:0] TOP_8    = CNT_W'((1 << 8) - 1);
  localparam logic [CNT_W-1:0] TOP_9    = CNT_W'((1 << 9) - 1);
  localparam logic [CNT_W-1:0] TOP_10   = CNT_W'((1 << 10) - 1);

  always_comb begin
    cfg = decode_mode(mode);
    case (cfg.res_sel)
      2'd1:    fixed_top = TOP_8;
      2'd2:    fixed_top = TOP_9;
      2'd3:    fixed_top = TOP_10;
      default: fixed_top = TOP_FULL;
    endcase
  end
endmodule

// File: rtl/wgt_counter.sv
module wgt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dual,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] count,
  output logic             dir_down,
  output logic             at_top,
  output logic             at_bot
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_nxt;
  logic             dir_nxt;

  always_comb begin
    at_top  = (count == top);
    at_bot  = (count == '0);
    cnt_nxt = count + ONE;
    dir_nxt = 1'b0;
    if (!dual) begin
      if (at_top) cnt_nxt = '0;
    end else if (!dir_down) begin
      if (count >= top) begin
        cnt_nxt = count - ONE;
        dir_nxt = 1'b1;
      end
    end else if (!at_bot) begin
      cnt_nxt = count - ONE;
      dir_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      dir_down <= 1'b0;
    end else begin
      if (tick) count <= cnt_nxt;
      if (!dual)     dir_down <= 1'b0;
      else if (tick) dir_down <= dir_nxt;
    end
  end
endmodule

// File: rtl/wgt_compare.sv
module wgt_compare
  import wgt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  load_pt_e         load_pt,
  input  logic             at_top,
  input  logic             at_bot,
  output logic [CNT_W-1:0] cmp_live
);
  logic [CNT_W-1:0] cmp_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_buf  <= '0;
      cmp_live <= '0;
    end else begin
      if (wr) cmp_buf <= wdata;
      case (load_pt)
        LD_NOW:  cmp_live <= wr ? wdata : cmp_buf;
        LD_TOP:  if (tick && at_top) cmp_live <= cmp_buf;
        LD_BOT:  if (tick && at_bot) cmp_live <= cmp_buf;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wavegen_timer16.sv
module wavegen_timer16
  import wgt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [1:0]       mode_hi,
  input  logic [1:0]       mode_lo,
  input  logic             cmpa_wr,
  input  logic [CNT_W-1:0] cmpa_wdata,
  input  logic             capt_wr,
  input  logic [CNT_W-1:0] capt_wdata,
  input  logic             ovf_clr,
  input  logic             cmf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             cmf_flag,
  output logic             wave_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [3:0]       mode;
  mode_cfg_t        cfg;
  logic [CNT_W-1:0] fixed_top;
  logic [CNT_W-1:0] top_val;
  logic [CNT_W-1:0] capt_q;
  logic [CNT_W-1:0] cmp_live;
  logic             dir_down;
  logic             at_top;
  logic             at_bot;
  logic             dual;
  logic             ovf_hit;
  logic             cmf_hit;

  assign mode = {mode_hi, mode_lo};
  assign dual = (cfg.kind == WK_DUAL);

  wgt_mode_decode #(.CNT_W(CNT_W)) u_dec (
    .mode      (mode),
    .cfg       (cfg),
    .fixed_top (fixed_top)
  );

  always_comb begin
    case (cfg.top_src)
      TS_CMPA: top_val = cmp_live;
      TS_CAPT: top_val = capt_q;
      default: top_val = fixed_top;
    endcase
  end

  wgt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cnt_en),
    .dual     (dual),
    .top      (top_val),
    .count    (count),
    .dir_down (dir_down),
    .at_top   (at_top),
    .at_bot   (at_bot)
  );

  wgt_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cnt_en),
    .wr       (cmpa_wr),
    .wdata    (cmpa_wdata),
    .load_pt  (cfg.load_pt),
    .at_top   (at_top),
    .at_bot   (at_bot),
    .cmp_live (cmp_live)
  );

  always_comb begin
    case (cfg.ovf_pt)
      OV_TOP:  ovf_hit = cnt_en && at_top;
      OV_BOT:  ovf_hit = cnt_en && at_bot;
      default: ovf_hit = cnt_en && (count == CNT_MAX);
    endcase
    cmf_hit = cnt_en && (count == cmp_live);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capt_q   <= '0;
      ovf_flag <= 1'b0;
      cmf_flag <= 1'b0;
      wave_out <= 1'b0;
    end else begin
      if (capt_wr) capt_q <= capt_wdata;
      if (ovf_hit)      ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
      if (cmf_hit)      cmf_flag <= 1'b1;
      else if (cmf_clr) cmf_flag <= 1'b0;
      if (cnt_en) begin
        case (cfg.kind)
          WK_FAST: begin
            if (at_top)                     wave_out <= 1'b1;
            else if (count == cmp_live)     wave_out <= 1'b0;
          end
          WK_DUAL: if (count == cmp_live) wave_out <= dir_down;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wgt_checker.sv
module wgt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [1:0]       mode_hi,
  input logic [1:0]       mode_lo,
  input logic             cmf_clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_live,
  input logic             cmf_flag,
  input logic             wave_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [3:0] m;
  logic       ud;
  logic       plain;

  assign m     = {mode_hi, mode_lo};
  assign ud    = m inside {4'd1, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10, 4'd11};
  assign plain = m inside {4'd0, 4'd4, 4'd12, 4'd13};

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));

  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !ud) |=> (count == $past(count) + ONE) || (count == '0));

  assert_updown_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && ud) |=> (count == $past(count) + ONE) || (count == $past(count) - ONE));

  assert_match_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && count == cmp_live) |=> cmf_flag);

  assert_clear_wins_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmf_clr && !(cnt_en && count == cmp_live)) |=> !cmf_flag);

  assert_plain_pin_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    plain |=> $stable(wave_out));
endmodule

bind wavegen_timer16 wgt_checker #(.CNT_W(CNT_W)) u_wgt_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .mode_hi  (mode_hi),
  .mode_lo  (mode_lo),
  .cmf_clr  (cmf_clr),
  .count    (count),
  .cmp_live (cmp_live),
  .cmf_flag (cmf_flag),
  .wave_out (wave_out)
);

// File: tb/wavegen_timer16_bench.sv
`timescale 1ns/1ps
module wavegen_timer16_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [1:0]  mode_hi = 2'd0;
  logic [1:0]  mode_lo = 2'd0;
  logic        cmpa_wr = 1'b0;
  logic [15:0] cmpa_wdata = '0;
  logic        capt_wr = 1'b0;
  logic [15:0] capt_wdata = '0;
  logic        ovf_clr = 1'b0;
  logic        cmf_clr = 1'b0;
  logic [15:0] count;
  logic        ovf_flag;
  logic        cmf_flag;
  logic        wave_out;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_cnt, m_down, m_buf, m_live, m_cap, m_ovf, m_cmf, m_pin;
  int cur_mode = 0;

  always #2.5 clk = ~clk;

  wavegen_timer16 u_wavegen_timer16 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_hi(mode_hi), .mode_lo(mode_lo),
    .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata), .capt_wr(capt_wr), .capt_wdata(capt_wdata),
    .ovf_clr(ovf_clr), .cmf_clr(cmf_clr), .count(count), .ovf_flag(ovf_flag),
    .cmf_flag(cmf_flag), .wave_out(wave_out)
  );

  function automatic bit is_dual(int md);
    return md inside {1, 2, 3, 8, 9, 10, 11};
  endfunction

  function automatic bit is_fast(int md);
    return md inside {5, 6, 7, 14, 15};
  endfunction

  function automatic int limit_of(int md);
    case (md)
      1, 5:          return 255;
      2, 6:          return 511;
      3, 7:          return 1023;
      4, 9, 11, 15:  return m_live;
      8, 10, 12, 14: return m_cap;
      default:       return 65535;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_down = 0; m_buf = 0; m_live = 0; m_cap = 0;
    m_ovf = 0; m_cmf = 0; m_pin = 0;
  endtask

  task automatic model_step();
    int t, c, nc, nd, nlive;
    bit en, ovf_set;
    t = limit_of(cur_mode);
    c = m_cnt; nc = c; nd = m_down; nlive = m_live;
    en = cnt_en;
    ovf_set = 0;
    if (en) begin
      if (is_dual(cur_mode)) begin
        if (m_down == 0) begin
          if (c >= t) begin nc = (c + 65535) % 65536; nd = 1; end
          else nc = c + 1;
        end else begin
          if (c == 0) begin nc = 1; nd = 0; end
          else nc = c - 1;
        end
        ovf_set = (c == 0);
        if (c == m_live) m_pin = m_down;
      end else begin
        nc = (c == t) ? 0 : (c + 1) % 65536;
        if (is_fast(cur_mode)) begin
          ovf_set = (c == t);
          if (c == t) m_pin = 1;
          else if (c == m_live) m_pin = 0;
        end else ovf_set = (c == 65535);
      end
    end
    if (!is_dual(cur_mode)) nd = 0;
    if (ovf_set) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
    if (en && c == m_live) m_cmf = 1; else if (cmf_clr) m_cmf = 0;
    if (cur_mode inside {0, 4, 12, 13}) nlive = cmpa_wr ? int'(cmpa_wdata) : m_buf;
    else if (cur_mode inside {1, 2, 3, 10, 11}) begin
      if (en && c == t) nlive = m_buf;
    end else begin
      if (en && c == 0) nlive = m_buf;
    end
    if (cmpa_wr) m_buf = cmpa_wdata;
    if (capt_wr) m_cap = capt_wdata;
    m_live = nlive; m_cnt = nc; m_down = nd;
  endtask

  task automatic check_bit(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check_bit(tag, "count", int'(count), m_cnt);
    check_bit(tag, "ovf_flag", int'(ovf_flag), m_ovf);
    check_bit(tag, "cmf_flag", int'(cmf_flag), m_cmf);
    check_bit(tag, "wave_out", int'(wave_out), m_pin);
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(tag);
    cmpa_wr = 1'b0; capt_wr = 1'b0; ovf_clr = 1'b0; cmf_clr = 1'b0;
  endtask

  task automatic set_mode(int md);
    cur_mode = md;
    mode_hi = 2'(md >> 2);
    mode_lo = 2'(md & 3);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cnt_en = 1'b0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
  endtask

  // gap: enable low on every gap-th cycle (0 = always on); clr: clear pulses period
  task automatic run(int n, string tag, int gap, int clr);
    for (int i = 0; i < n; i++) begin
      cnt_en = (gap == 0) ? 1'b1 : ((i % gap) != gap - 1);
      if (clr != 0 && (i % clr) == 0) begin ovf_clr = 1'b1; cmf_clr = 1'b1; end
      cycle(tag);
    end
  endtask

  task automatic write_cmp(int v, string tag);
    cnt_en = 1'b0; cmpa_wr = 1'b1; cmpa_wdata = 16'(v);
    cycle(tag);
  endtask

  task automatic write_cap(int v, string tag);
    cnt_en = 1'b0; capt_wr = 1'b1; capt_wdata = 16'(v);
    cycle(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    set_mode(0);
    do_reset();                       // R1 reset values
    // R2: gated enable, count holds on idle cycles
    write_cmp(20, "R2");
    run(60, "R2", 3, 0);
    // R8/R9: match flags with clear pulses, including clear in set cycles
    run(80, "R9", 0, 5);
    // R7: mode 0 runs through 0xFFFF
    run(65600, "R7", 0, 0);

    // R10/R6: fast 8-bit, buffered compare loads at zero
    do_reset(); set_mode(5);
    write_cmp(64, "R6");
    run(300, "R10", 0, 0);
    write_cmp(144, "R6");
    run(600, "R10", 7, 0);

    // R11/R5/R6: dual slope 8-bit, buffer loads at TOP
    do_reset(); set_mode(1);
    write_cmp(48, "R6");
    run(600, "R11", 0, 0);
    write_cmp(128, "R6");
    run(700, "R5", 0, 90);

    // R3: remaining fixed-limit modes
    for (int k = 0; k < 4; k++) begin
      int mlist[4] = '{2, 3, 6, 7};
      do_reset(); set_mode(mlist[k]);
      write_cmp(100, "R3");
      run(2200, "R3", 0, 0);
    end

    // R4/R6/R12: register-sourced limits and the reserved code
    for (int k = 0; k < 9; k++) begin
      int mlist[9] = '{4, 12, 8, 9, 10, 11, 14, 15, 13};
      do_reset(); set_mode(4);
      write_cmp(50, "R4");
      write_cap(70, "R4");
      run(5, "R4", 0, 0);
      set_mode(mlist[k]);
      run(150, (mlist[k] == 13) ? "R12" : "R4", 0, 0);
      write_cmp(30, "R6");
      run(250, (mlist[k] inside {4, 12, 13}) ? "R12" : "R6", 4, 60);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule